// File: doc/BRIEF.md
# Integrity Tree Walk Sequencer

This block steps through the verification and update walks of a counter tree that protects a region of external memory. The tree has four levels: one version per data line, then L0, L1 and L2 counter lines, each covering eight children. The top level is a small array of counters that stays on chip and is trusted without any check. A request carries a direction (read or write) and a cache-line index. The sequencer fetches the data line together with its tag, then the counter lines from the bottom upward. A fetch that reports a metadata-cache hit ends the climb, because that counter is already trusted. When the climb ends, each fetched node goes to an external tag engine, from the top of the walk down to the data. With each node the sequencer sends the nonce that was read from the level above.

A read is released only after every comparison has passed. A write first runs the same full verification. It then sends one update per level, from the bottom up, carrying the incremented counters. If the walk reached the top, it also advances the on-chip root counter. A mismatch against any nonce other than the initial value drops the transaction and locks the block until reset. A counter increment that would wrap also drops and locks. A mismatch under a parent that still holds the initial value means "never written", so it is ignored. Cipher work, tag arithmetic, memory timing and address derivation all sit behind simple request/acknowledge ports.

Top module: `tw_walker`

## Requirements
- R1: During reset and after it, `lock` is low. The root counters are loaded with the initial value 1 (the field's multiplicative unit), one entry per clock. `req_ready` first goes high on the (ROOT_N+1)-th rising edge after reset is released.
- R2: Fetches are issued in level order, using the codes 0 for data plus tag, 1 for version, 2 for L0, 3 for L1 and 4 for L2. A fetch acknowledged with `fetch_hit` at level 1 or above is the last fetch. After L2 with no hit, the root counter at index `req_addr[4*ARY_LOG +: log2(ROOT_N)]` is used as the top nonce.
- R3: Comparisons run from the level just below the top of the walk down to level 0. Each carries, as its nonce, the counter of the level directly above it. A read pulses `rd_approve` only after the level-0 comparison has been accepted.
- R4: A failed comparison whose nonce is not the initial value pulses `drop` and issues no further comparisons. It raises `lock` permanently. From then on `req_ready` stays low and no fetch is issued until reset.
- R5: A failed comparison whose nonce equals the initial value is treated as a pass.
- R6: A write issues no update until all of its comparisons have completed. Updates then run in ascending level order, from 0 up to the top of the walk (capped at 4). Each update carries the node's incremented counter in `upd_field`. Below the top, it also carries the incremented counter of the level above in `upd_nonce`, with `upd_retag` high.
- R7: On a write, a node whose parent counter in the walk equals the initial value gets the value x (binary 10) and `upd_sib_init` high. When the walk reached the root, the root entry is replaced by its increment.
- R8: On a write, if any counter increment along the walk would produce the initial value again, the block pulses `drop`, locks, and issues no update.
- R9: `busy` is high from the cycle after acceptance until the single `rd_approve`, `wr_done` or `drop` pulse. It is low during that pulse, and at most one of the three pulses is high in any cycle.
- R10: Incrementing a counter multiplies it by x modulo the field polynomial: a left shift, followed by an XOR with `POLY` when the bit shifted out was one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write walk, 0 = read walk |
| req_addr | input | AW | Cache-line index of the request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| busy | output | 1 | Walk in progress |
| fetch_req | output | 1 | Node fetch request, held until acknowledged |
| fetch_lvl | output | 3 | Level of the node to fetch |
| fetch_addr | output | AW | Line index of the request being walked |
| fetch_ack | input | 1 | Fetch complete |
| fetch_ctr | input | CW | Counter field in the fetched node covering the child |
| fetch_hit | input | 1 | Fetched counter came from the metadata cache |
| cmp_req | output | 1 | Tag comparison request |
| cmp_lvl | output | 3 | Level of the node to compare |
| cmp_nonce | output | CW | Nonce of the level above |
| cmp_ack | input | 1 | Comparison complete |
| cmp_pass | input | 1 | Tag matched |
| upd_req | output | 1 | Update request |
| upd_lvl | output | 3 | Level being updated |
| upd_field | output | CW | New counter value for the node (0 at level 0) |
| upd_nonce | output | CW | New counter of the level above, for recomputing the tag |
| upd_sib_init | output | 1 | Set the node's sibling counters to the initial value |
| upd_retag | output | 1 | Recompute this node's tag |
| upd_ack | input | 1 | Update complete |
| rd_approve | output | 1 | Read data released (pulse) |
| wr_done | output | 1 | Write walk finished (pulse) |
| drop | output | 1 | Transaction discarded (pulse) |
| lock | output | 1 | Sticky failure lock |

## Verification
The bench builds the block with 8-bit counters under the primitive polynomial x^8+x^4+x^3+x^2+1, four root entries and a 16-bit line index. With 8-bit counters, a counter one step short of wrapping (0x8E) can be handed in directly, so the rollover lock is reachable. With four root entries, the reset sweep is short enough to count cycle by cycle, and two requests whose index bits 13:12 differ land on separate roots. A second reset in mid-run shows that the lock clears and that a root advanced by an earlier write returns to the initial value.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [2:0] {
      S_RINIT,
      S_IDLE,
      S_FETCH,
      S_CHECK,
      S_UPD,
      S_LOCK
   } tw_state_e;

   localparam int unsigned LVW     = 3;
   localparam int unsigned LV_DATA = 0;
   localparam int unsigned LV_VER  = 1;
   localparam int unsigned LV_L2   = 4;
   localparam int unsigned LV_ROOT = 5;
   localparam int unsigned NUM_LV  = 6;

endpackage

// File: rtl/tw_ctr_step.sv
module tw_ctr_step #(
   parameter int unsigned     CW   = 56,
   parameter logic [CW-1:0]   POLY = '0
) (
   input  logic [CW-1:0] a,
   output logic [CW-1:0] nxt
);
   // multiply by x in GF(2^CW): shift, reduce when the top bit leaves
   assign nxt = {a[CW-2:0], 1'b0} ^ (a[CW-1] ? POLY : '0);
endmodule

// File: rtl/tw_root_store.sv
module tw_root_store #(
   parameter int unsigned   CW       = 56,
   parameter int unsigned   ROOT_N   = 64,
   parameter int unsigned   IW       = 6,
   parameter logic [CW-1:0] INIT_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic [CW-1:0] rd_val,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [CW-1:0] wr_val,
   output logic          init_done
);
   logic [IW-1:0] sweep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sweep_q   <= '0;
         init_done <= 1'b0;
      end else if (!init_done) begin
         if (sweep_q == IW'(ROOT_N - 1)) init_done <= 1'b1;
         else                            sweep_q   <= sweep_q + 1'b1;
      end
   end

   generate
      if (ROOT_N == 1) begin : g_single
         logic [CW-1:0] root_q;
         always_ff @(posedge clk) begin
            if (!init_done)  root_q <= INIT_VAL;
            else if (wr_en)  root_q <= wr_val;
         end
         assign rd_val = root_q;
      end else begin : g_array
         logic [CW-1:0] mem_q [ROOT_N];
         always_ff @(posedge clk) begin
            if (!init_done)  mem_q[sweep_q] <= INIT_VAL;
            else if (wr_en)  mem_q[wr_idx]  <= wr_val;
         end
         assign rd_val = mem_q[rd_idx];
      end
   endgenerate

   // R1: roots may only be rewritten by a walk once the sweep has finished
   assert_wr_after_sweep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> init_done);
endmodule

// File: rtl/tw_walker.sv
module tw_walker #(
   parameter int unsigned   AW      = 34,
   parameter int unsigned   CW      = 56,
   parameter int unsigned   ARY_LOG = 3,
   parameter int unsigned   ROOT_N  = 64,
   parameter logic [CW-1:0] POLY    = 56'h8000_0C00_0000_01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          busy,
   output logic          fetch_req,
   output logic [2:0]    fetch_lvl,
   output logic [AW-1:0] fetch_addr,
   input  logic          fetch_ack,
   input  logic [CW-1:0] fetch_ctr,
   input  logic          fetch_hit,
   output logic          cmp_req,
   output logic [2:0]    cmp_lvl,
   output logic [CW-1:0] cmp_nonce,
   input  logic          cmp_ack,
   input  logic          cmp_pass,
   output logic          upd_req,
   output logic [2:0]    upd_lvl,
   output logic [CW-1:0] upd_field,
   output logic [CW-1:0] upd_nonce,
   output logic          upd_sib_init,
   output logic          upd_retag,
   input  logic          upd_ack,
   output logic          rd_approve,
   output logic          wr_done,
   output logic          drop,
   output logic          lock
);
   import tw_pkg::*;

   localparam int unsigned   RIW      = (ROOT_N > 1) ? $clog2(ROOT_N) : 1;
   localparam int unsigned   ROOT_SH  = 4 * ARY_LOG;
   localparam logic [CW-1:0] INIT_VAL = CW'(1);

   initial begin
      assert_cw_ok: assert (CW >= 2) else $error("counter width too small");
      assert_root_pow2: assert ((ROOT_N & (ROOT_N - 1)) == 0) else $error("ROOT_N not a power of two");
      assert_aw_ok: assert (AW >= ROOT_SH + RIW) else $error("address too narrow for tree");
   end

   tw_state_e     st_q;
   logic [2:0]    lvl_q, top_q;
   logic          wr_q, locked_q, approve_q, done_q, drop_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] ctr_q   [NUM_LV];
   logic [CW-1:0] nxt     [NUM_LV];
   logic          uninit  [NUM_LV];
   logic          roll    [NUM_LV];
   logic          roll_any;
   logic [CW-1:0] par_ctr, par_nxt, root_rd;
   logic [2:0]    last_upd;
   logic          root_init_done, root_we;
   logic [RIW-1:0] ridx;

   assign ridx = addr_q[ROOT_SH +: RIW];

   // next values for every counter on the walk
   assign nxt[0]    = '0;
   assign uninit[0] = 1'b0;
   assign roll[0]   = 1'b0;
   generate
      for (genvar k = 1; k < NUM_LV; k++) begin : g_lv
         logic [CW-1:0] step;
         if (k < NUM_LV - 1) begin : g_below
            assign uninit[k] = (3'(k) < top_q) && (ctr_q[k+1] == INIT_VAL);
         end else begin : g_top
            assign uninit[k] = 1'b0;
         end
         tw_ctr_step #(.CW(CW), .POLY(POLY)) i_step (
            .a   (uninit[k] ? INIT_VAL : ctr_q[k]),
            .nxt (step)
         );
         assign nxt[k]  = step;
         assign roll[k] = (3'(k) <= top_q) && (step == INIT_VAL);
      end
   endgenerate

   always_comb begin
      roll_any = 1'b0;
      for (int k = 0; k < NUM_LV; k++) roll_any = roll_any | roll[k];
      par_ctr = '0;
      par_nxt = '0;
      for (int k = 0; k < NUM_LV - 1; k++) begin
         if (lvl_q == 3'(k)) begin
            par_ctr = ctr_q[k+1];
            par_nxt = nxt[k+1];
         end
      end
   end

   assign last_upd = (top_q == 3'(LV_ROOT)) ? 3'(LV_L2) : top_q;
   assign root_we  = (st_q == S_UPD) && upd_ack && (lvl_q == last_upd)
                     && (top_q == 3'(LV_ROOT));

   tw_root_store #(.CW(CW), .ROOT_N(ROOT_N), .IW(RIW), .INIT_VAL(INIT_VAL)) i_root (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (ridx),
      .rd_val    (root_rd),
      .wr_en     (root_we),
      .wr_idx    (ridx),
      .wr_val    (nxt[LV_ROOT]),
      .init_done (root_init_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_RINIT;
         lvl_q     <= '0;
         top_q     <= '0;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         locked_q  <= 1'b0;
         approve_q <= 1'b0;
         done_q    <= 1'b0;
         drop_q    <= 1'b0;
         for (int k = 0; k < NUM_LV; k++) ctr_q[k] <= '0;
      end else begin
         approve_q <= 1'b0;
         done_q    <= 1'b0;
         drop_q    <= 1'b0;
         case (st_q)
            S_RINIT: if (root_init_done) st_q <= S_IDLE;
            S_IDLE: if (req_valid) begin
               wr_q   <= req_write;
               addr_q <= req_addr;
               lvl_q  <= 3'(LV_DATA);
               st_q   <= S_FETCH;
            end
            S_FETCH: if (fetch_ack) begin
               ctr_q[lvl_q] <= fetch_ctr;
               if (lvl_q != 3'(LV_DATA) && fetch_hit) begin
                  top_q <= lvl_q;
                  lvl_q <= lvl_q - 1'b1;
                  st_q  <= S_CHECK;
               end else if (lvl_q == 3'(LV_L2)) begin
                  ctr_q[LV_ROOT] <= root_rd;
                  top_q <= 3'(LV_ROOT);
                  st_q  <= S_CHECK;
               end else begin
                  lvl_q <= lvl_q + 1'b1;
               end
            end
            S_CHECK: if (cmp_ack) begin
               if (!cmp_pass && par_ctr != INIT_VAL) begin
                  locked_q <= 1'b1;
                  drop_q   <= 1'b1;
                  st_q     <= S_LOCK;
               end else if (lvl_q != 3'(LV_DATA)) begin
                  lvl_q <= lvl_q - 1'b1;
               end else if (!wr_q) begin
                  approve_q <= 1'b1;
                  st_q      <= S_IDLE;
               end else if (roll_any) begin
                  locked_q <= 1'b1;
                  drop_q   <= 1'b1;
                  st_q     <= S_LOCK;
               end else begin
                  lvl_q <= 3'(LV_DATA);
                  st_q  <= S_UPD;
               end
            end
            S_UPD: if (upd_ack) begin
               if (lvl_q == last_upd) begin
                  done_q <= 1'b1;
                  st_q   <= S_IDLE;
               end else begin
                  lvl_q <= lvl_q + 1'b1;
               end
            end
            default: st_q <= S_LOCK;
         endcase
      end
   end

   assign req_ready  = (st_q == S_IDLE);
   assign busy       = (st_q == S_FETCH) || (st_q == S_CHECK) || (st_q == S_UPD);
   assign fetch_req  = (st_q == S_FETCH);
   assign fetch_lvl  = lvl_q;
   assign fetch_addr = addr_q;
   assign cmp_req    = (st_q == S_CHECK);
   assign cmp_lvl    = lvl_q;
   assign cmp_nonce  = par_ctr;
   assign upd_req    = (st_q == S_UPD);
   assign upd_lvl    = lvl_q;
   assign upd_retag  = (lvl_q < top_q);
   assign upd_nonce  = (lvl_q < top_q) ? par_nxt : '0;

   always_comb begin
      upd_field    = '0;
      upd_sib_init = 1'b0;
      for (int k = 1; k < NUM_LV; k++) begin
         if (lvl_q == 3'(k)) begin
            upd_field    = nxt[k];
            upd_sib_init = uninit[k];
         end
      end
   end

   assign rd_approve = approve_q;
   assign wr_done    = done_q;
   assign drop       = drop_q;
   assign lock       = locked_q;

   // R4: once locked, nothing is accepted and the lock never clears
   assert_locked_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> !req_ready && !fetch_req);
   assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);
   // R9: one outcome at a time, and busy only falls with an outcome
   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_approve, wr_done, drop}));
   assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (rd_approve || wr_done || drop));
   // R2: a pending fetch keeps its level until acknowledged
   assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_lvl)));
   // R6: updates only ever belong to writes
   assert_upd_only_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |-> wr_q);
   // R3: a read is approved only right after a level-0 comparison
   assert_approve_after_l0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_approve |-> ($past(cmp_req) && $past(cmp_ack) && $past(cmp_lvl) == 3'(LV_DATA)));
endmodule

// File: tb/test_tw_walker.sv
module test_tw_walker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int CW = 8;
   localparam int ROOT_N = 4;

   typedef struct {
      int code;
      int nf;
      int nc;
      int nu;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, busy;
   logic fetch_req, fetch_ack = 0, fetch_hit = 0;
   logic [2:0] fetch_lvl, cmp_lvl, upd_lvl;
   logic [AW-1:0] fetch_addr;
   logic [CW-1:0] fetch_ctr = '0, cmp_nonce, upd_field, upd_nonce;
   logic cmp_req, cmp_ack = 0, cmp_pass = 0;
   logic upd_req, upd_ack = 0, upd_sib_init, upd_retag;
   logic rd_approve, wr_done, drop, lock;

   tw_walker #(.AW(AW), .CW(CW), .ARY_LOG(3), .ROOT_N(ROOT_N), .POLY(8'h1D)) i_tw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .busy(busy),
      .fetch_req(fetch_req), .fetch_lvl(fetch_lvl), .fetch_addr(fetch_addr),
      .fetch_ack(fetch_ack), .fetch_ctr(fetch_ctr), .fetch_hit(fetch_hit),
      .cmp_req(cmp_req), .cmp_lvl(cmp_lvl), .cmp_nonce(cmp_nonce),
      .cmp_ack(cmp_ack), .cmp_pass(cmp_pass),
      .upd_req(upd_req), .upd_lvl(upd_lvl), .upd_field(upd_field),
      .upd_nonce(upd_nonce), .upd_sib_init(upd_sib_init), .upd_retag(upd_retag),
      .upd_ack(upd_ack), .rd_approve(rd_approve), .wr_done(wr_done),
      .drop(drop), .lock(lock)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0, fails = 0;
   exp_t exp_q[$];
   // responder configuration
   logic [CW-1:0] r_ctr [8];
   int r_hit = 7, r_fail = 7;
   // observed per request
   int nf = 0, nc = 0, nu = 0, first_nc = -1;
   logic [CW-1:0] seen_nonce [8];
   logic [CW-1:0] u_field [8];
   logic [CW-1:0] u_nonce [8];
   logic u_sib [8];
   logic u_retag [8];

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // responder and monitor in one process
   always @(negedge clk) begin
      if (!rst_n) begin
         nf = 0; nc = 0; nu = 0; first_nc = -1;
         fetch_ack = 0; cmp_ack = 0; upd_ack = 0;
      end else begin
         fetch_ack = fetch_req;
         if (fetch_req) begin
            chk(fetch_lvl == 3'(nf), "R2 fetch order", fetch_lvl, nf);
            fetch_ctr = r_ctr[fetch_lvl];
            fetch_hit = (int'(fetch_lvl) == r_hit);
            nf++;
         end
         cmp_ack = cmp_req;
         if (cmp_req) begin
            cmp_pass = (int'(cmp_lvl) != r_fail);
            seen_nonce[cmp_lvl] = cmp_nonce;
            nc++;
         end
         upd_ack = upd_req;
         if (upd_req) begin
            if (nu == 0) first_nc = nc;
            u_field[upd_lvl] = upd_field;
            u_nonce[upd_lvl] = upd_nonce;
            u_sib[upd_lvl]   = upd_sib_init;
            u_retag[upd_lvl] = upd_retag;
            nu++;
         end
         if (rd_approve || wr_done || drop) begin
            int code;
            code = rd_approve ? 1 : (wr_done ? 2 : 3);
            chk(!busy, "R9 busy low at outcome", busy, 0);
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected outcome", code, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(code == e.code, "R3/R4/R8 outcome", code, e.code);
               chk(nf == e.nf, "R2 fetch count", nf, e.nf);
               chk(nc == e.nc, "R3 compare count", nc, e.nc);
               chk(nu == e.nu, "R6 update count", nu, e.nu);
            end
            nf = 0; nc = 0; nu = 0;
         end
      end
   end

   task automatic run(bit w, logic [AW-1:0] a, int code, int enf, int enc, int enu);
      exp_t e;
      e.code = code; e.nf = enf; e.nc = enc; e.nu = enu;
      exp_q.push_back(e);
      first_nc = -1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      chk(busy, "R9 busy after accept", busy, 1);
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic do_reset();
      int lows;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(!lock, "R1 lock low in reset", lock, 0);
      rst_n = 1;
      lows = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (req_ready) break;
         lows++;
      end
      chk(lows == ROOT_N, "R1 ready delay", lows, ROOT_N);
      chk(!lock, "R1 lock low after reset", lock, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      r_ctr[0] = 8'h00; r_ctr[1] = 8'h10; r_ctr[2] = 8'h20; r_ctr[3] = 8'h30;
      r_ctr[4] = 8'h40; r_ctr[5] = 8'h00; r_ctr[6] = 8'h00; r_ctr[7] = 8'h00;
      do_reset();

      // R5: L2 mismatch under an untouched root is ignored; R2/R3 full walk
      r_hit = 7; r_fail = 4;
      run(0, 16'h0000, 1, 5, 5, 0);
      chk(seen_nonce[4] == 8'h01, "R3 root nonce", seen_nonce[4], 8'h01);
      chk(seen_nonce[0] == 8'h10, "R3 version nonce", seen_nonce[0], 8'h10);

      // R2: hit at version level stops after data and tag line
      r_fail = 7; r_hit = 1; r_ctr[1] = 8'h11;
      run(0, 16'h0008, 1, 2, 1, 0);
      chk(seen_nonce[0] == 8'h11, "R3 cached version nonce", seen_nonce[0], 8'h11);

      // R6/R10: write with hit at version level
      run(1, 16'h0008, 2, 2, 1, 2);
      chk(first_nc == 1, "R6 verify before update", first_nc, 1);
      chk(u_field[1] == 8'h22, "R10 version increment", u_field[1], 8'h22);
      chk(u_nonce[0] == 8'h22, "R6 data retag nonce", u_nonce[0], 8'h22);
      chk(u_retag[0] && !u_retag[1], "R6 retag flags", {u_retag[0], u_retag[1]}, 2'b10);

      // R7: full write under an untouched root (index 1)
      r_hit = 7;
      run(1, 16'h1000, 2, 5, 5, 5);
      chk(first_nc == 5, "R6 all compares first", first_nc, 5);
      chk(u_field[4] == 8'h02 && u_sib[4], "R7 uninit L2 node", {u_sib[4], u_field[4]}, 9'h102);
      chk(u_nonce[4] == 8'h02, "R7 new root nonce", u_nonce[4], 8'h02);
      chk(u_field[2] == 8'h40 && !u_sib[2], "R10 L0 increment", u_field[2], 8'h40);
      chk(u_field[3] == 8'h60 && u_nonce[3] == 8'h02, "R6 L1 update", {u_field[3], u_nonce[3]}, 16'h6002);

      // R7: root 1 advanced, root 0 untouched
      run(0, 16'h1000, 1, 5, 5, 0);
      chk(seen_nonce[4] == 8'h02, "R7 root advanced", seen_nonce[4], 8'h02);
      run(0, 16'h0000, 1, 5, 5, 0);
      chk(seen_nonce[4] == 8'h01, "R7 other root kept", seen_nonce[4], 8'h01);

      // R5: mismatch at L0 under an initial-value L1 counter is ignored
      r_ctr[3] = 8'h01; r_fail = 2;
      run(0, 16'h1000, 1, 5, 5, 0);
      r_ctr[3] = 8'h30; r_fail = 7;

      // R8: version 0x8E would wrap to 1
      r_hit = 1; r_ctr[1] = 8'h8E;
      run(1, 16'h0008, 3, 2, 1, 0);
      chk(lock, "R8 lock after rollover", lock, 1);

      // R4: locked block refuses requests
      req_valid = 1; req_write = 0;
      repeat (5) @(negedge clk);
      chk(!req_ready, "R4 ready low when locked", req_ready, 0);
      chk(nf == 0, "R4 no fetch when locked", nf, 0);
      req_valid = 0;

      // R1: reset clears lock and roots
      do_reset();
      r_hit = 7; r_ctr[1] = 8'h10;
      run(0, 16'h1000, 1, 5, 5, 0);
      chk(seen_nonce[4] == 8'h01, "R1 root reinitialised", seen_nonce[4], 8'h01);

      // R4: real mismatch at L1 against nonce 0x40
      r_fail = 3;
      run(0, 16'h1000, 3, 5, 2, 0);
      chk(lock, "R4 lock after mismatch", lock, 1);
      repeat (3) @(negedge clk);
      chk(lock && !req_ready, "R4 lock sticky", lock, 1);

      report();
      $finish;
   end
endmodule